// File: doc/BRIEF.md
# Multi-Stream Stride Data Prefetcher

This block watches the demand accesses of a processor's data side and, for each of several independent access streams, learns a constant distance between consecutive block addresses. Each demand access carries a block address and a small stream tag, for example an index derived from the load instruction's address. Once a stream has shown the same nonzero distance twice in a row, the block starts sending prefetch requests for the blocks that lie ahead along that stride, toward the next memory level.

How far ahead a stream runs is set per stream. Each access carries a requested lookahead depth, which is clamped to the range 1 to `MAX_AHEAD`. Later accesses that keep the stride move the prefetch frontier forward by one stride each, so a steady stream stays a fixed number of strides ahead of its demand address. A stride of +1 with depth 1 gives the familiar next-block lookahead. Streams live in a small table of entries. When a new tag arrives and the table is full, the entry that was touched least recently is replaced.

Prefetch requests leave through a one-deep valid/ready output register. Demand traffic never waits for that register. A request that is generated while the register still holds an unaccepted request is discarded.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset, `pf_valid` is low, and it stays low until some stream has confirmed a stride.
- R2: Take a stream whose accesses are at blocks b, b+N and b+2N, with N nonzero and addresses wrapping modulo 2^BLK_W. No prefetch is requested before the third of these accesses. The first block requested is b+3N.
- R3: A stream's depth D is `dem_ahead`, with 0 read as 1 and any value above `MAX_AHEAD` read as `MAX_AHEAD`. D is taken from the access that allocates the entry and from every access with a nonzero distance. A confirmed stream whose last access was at block a requests the blocks a+N up to a+D·N, nearest first, at most one block per cycle across all streams.
- R4: With stride +1 and depth 1, each matching access to block a on a confirmed stream leads to exactly one request, for block a+1.
- R5: Each further access that matches the stride moves the frontier forward by exactly one stride. A stream never requests the same block twice while its stride holds.
- R6: An access whose distance from the last block differs from the stored stride does three things: it stores that distance as the new stride, it discards the stream's remaining prefetches, and it drops the stream back to one observed distance. Prefetching resumes only after one more access at the new stride, and it starts one new stride beyond that access.
- R7: An access to the same block as the stream's last access changes none of the stream's stride, confidence, depth or prefetch state. It only counts as a use for replacement.
- R8: A new tag takes the lowest-numbered free entry. When several entries have prefetches pending, the lowest-numbered entry is served first. Up to `NUM_STREAMS` streams are tracked independently.
- R9: When a new tag arrives and all entries are in use, the least recently accessed entry is replaced. The replacement starts with no stride history.
- R10: A generated request appears on `pf_valid`/`pf_blk` one cycle later, provided the output register is empty or is being accepted in that cycle. A request that is not accepted stays stable. Requests generated while it waits are discarded and never retried.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dem_valid | input | 1 | A demand access is present this cycle |
| dem_id | input | ID_W | Stream tag of the demand access |
| dem_blk | input | BLK_W | Block address of the demand access |
| dem_ahead | input | $clog2(MAX_AHEAD+1) | Requested lookahead depth, in strides |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The next level accepts the offered request |
| pf_blk | output | BLK_W | Block address to prefetch |

## Verification
The bench builds the block with its defaults: eight entries, a depth limit of 12, 26-bit block addresses and 6-bit tags. Random traffic spreads over twelve tags, which is more than the table holds, so replacement happens constantly during that phase. Requested depths from 0 to 15 reach both ends of the depth clamp, and a back-pressured output makes the discard path occur. Directed runs cover a negative stride, a stride change, repeated blocks and a hand-built replacement order. Their expected prefetch lists are worked out by hand.

// File: rtl/pfs_pkg.sv
// Package: shared types for the stride prefetcher.
// Assumes: nothing beyond standard SystemVerilog.
package pfs_pkg;

    // Confidence of a stream entry: no distance seen, one distance seen, stride confirmed
    typedef enum logic [1:0] {
        CF_NEW  = 2'd0,
        CF_ONE  = 2'd1,
        CF_SURE = 2'd2
    } conf_e;

endpackage

// File: rtl/pfs_entry.sv
// Module: one stream entry. It holds the tag, last block, stride, confidence,
// depth, prefetch frontier and lead (the number of strides already requested
// ahead of the last access).
// Assumes: alloc_i and hit_i are never both high. ahead_i is already clamped.
// Invariant while confirmed: npf == last + (lead+1)*stride.
module pfs_entry
    import pfs_pkg::*;
#(
    parameter int BLK_W   = 26,
    parameter int ID_W    = 6,
    parameter int AHEAD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  logic               hit_i,
    input  logic               grant_i,
    input  logic [ID_W-1:0]    id_i,
    input  logic [BLK_W-1:0]   blk_i,
    input  logic [AHEAD_W-1:0] ahead_i,
    output logic               valid_o,
    output logic [ID_W-1:0]    id_o,
    output logic               pend_o,
    output logic [BLK_W-1:0]   npf_o
);

    logic               vld_q, vld_d;
    logic [ID_W-1:0]    id_q, id_d;
    logic [BLK_W-1:0]   last_q, last_d, str_q, str_d, npf_q, npf_d, delta;
    conf_e              conf_q, conf_d;
    logic [AHEAD_W-1:0] lead_q, lead_d, depth_q, depth_d;

    assign delta = blk_i - last_q;

    // Next state: apply an issued prefetch first, then any demand access
    always_comb begin
        vld_d   = vld_q;
        id_d    = id_q;
        last_d  = last_q;
        str_d   = str_q;
        npf_d   = npf_q;
        conf_d  = conf_q;
        lead_d  = lead_q;
        depth_d = depth_q;
        if (grant_i) begin
            npf_d  = npf_q + str_q;
            lead_d = lead_q + AHEAD_W'(1);
        end
        if (alloc_i) begin
            vld_d   = 1'b1;
            id_d    = id_i;
            last_d  = blk_i;
            str_d   = '0;
            npf_d   = '0;
            conf_d  = CF_NEW;
            lead_d  = '0;
            depth_d = ahead_i;
        end else if (hit_i && (delta != '0)) begin
            depth_d = ahead_i;
            last_d  = blk_i;
            if (delta != str_q) begin
                str_d  = delta;
                conf_d = CF_ONE;
                lead_d = '0;
            end else if (conf_q == CF_ONE) begin
                conf_d = CF_SURE;
                lead_d = '0;
                npf_d  = blk_i + str_q;
            end else if (lead_d != '0) begin
                lead_d = lead_d - AHEAD_W'(1);
            end else begin
                npf_d = blk_i + str_q;
            end
        end
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            id_q    <= '0;
            last_q  <= '0;
            str_q   <= '0;
            npf_q   <= '0;
            conf_q  <= CF_NEW;
            lead_q  <= '0;
            depth_q <= '0;
        end else begin
            vld_q   <= vld_d;
            id_q    <= id_d;
            last_q  <= last_d;
            str_q   <= str_d;
            npf_q   <= npf_d;
            conf_q  <= conf_d;
            lead_q  <= lead_d;
            depth_q <= depth_d;
        end
    end

    assign valid_o = vld_q;
    assign id_o    = id_q;
    assign pend_o  = vld_q && (conf_q == CF_SURE) && (lead_q < depth_q);
    assign npf_o   = npf_q;

endmodule

// File: rtl/pfs_lru.sv
// Module: picks the entry for a new stream. A free entry wins, lowest index
// first. Otherwise the least recently touched entry is chosen. Recency is kept
// as a rank per entry, 0 for the newest and N-1 for the oldest.
// Assumes: the ranks always form a permutation of 0..N-1.
module pfs_lru #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    input  logic [N-1:0]     valid_i,
    output logic [IDX_W-1:0] victim_o
);

    logic [N-1:0][IDX_W-1:0] rank_q;
    logic                    free_found;

    // Rank update: the touched entry becomes newest, and newer ones age by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
        end else if (touch_i) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx_i)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx_i])
                    rank_q[i] <= rank_q[i] + IDX_W'(1);
            end
        end
    end

    // Victim choice: lowest free entry, otherwise the oldest rank
    always_comb begin
        free_found = 1'b0;
        victim_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (!valid_i[i] && !free_found) begin
                victim_o   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < N; i++)
                if (rank_q[i] == IDX_W'(N - 1)) victim_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pfs_arb.sv
// Module: fixed-priority choice of one pending entry per cycle. The lowest
// index wins, and its frontier block becomes the candidate request.
// Assumes: nothing. The grant is at most one-hot.
module pfs_arb #(
    parameter int N     = 8,
    parameter int BLK_W = 26
) (
    input  logic [N-1:0]            pend_i,
    input  logic [N-1:0][BLK_W-1:0] npf_i,
    output logic [N-1:0]            grant_o,
    output logic                    cand_v_o,
    output logic [BLK_W-1:0]        cand_blk_o
);

    // Lowest-index grant and the block it selects
    always_comb begin
        grant_o    = '0;
        cand_v_o   = 1'b0;
        cand_blk_o = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i] && !cand_v_o) begin
                grant_o[i] = 1'b1;
                cand_v_o   = 1'b1;
                cand_blk_o = npf_i[i];
            end
        end
    end

endmodule

// File: rtl/pfs_outq.sv
// Module: one-deep output register. It loads a candidate when it is empty or
// its content is accepted, holds while not ready, and lets later candidates be
// discarded.
// Assumes: the producer never waits on it.
module pfs_outq #(
    parameter int BLK_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_v_i,
    input  logic [BLK_W-1:0] cand_blk_i,
    input  logic             pf_ready,
    output logic             pf_valid,
    output logic [BLK_W-1:0] pf_blk
);

    // Load on free or accepted slot, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_blk   <= '0;
        end else if (!pf_valid || pf_ready) begin
            pf_valid <= cand_v_i;
            pf_blk   <= cand_blk_i;
        end
    end

endmodule

// File: rtl/stride_prefetcher.sv
// Module: top of the multi-stream stride prefetcher. It looks up the demand
// tag, allocates on a miss through the replacement picker, updates the
// entries, arbitrates one prefetch per cycle and drives the output register.
// Assumes: at most one demand access per cycle. Tags are unique in the table.
module stride_prefetcher
    import pfs_pkg::*;
#(
    parameter  int NUM_STREAMS = 8,
    parameter  int MAX_AHEAD   = 12,
    parameter  int BLK_W       = 26,
    parameter  int ID_W        = 6,
    localparam int AHEAD_W     = $clog2(MAX_AHEAD + 1),
    localparam int IDX_W       = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dem_valid,
    input  logic [ID_W-1:0]    dem_id,
    input  logic [BLK_W-1:0]   dem_blk,
    input  logic [AHEAD_W-1:0] dem_ahead,
    output logic               pf_valid,
    input  logic               pf_ready,
    output logic [BLK_W-1:0]   pf_blk
);

    logic [NUM_STREAMS-1:0]            vld_vec, match_vec, hit_vec, alloc_vec;
    logic [NUM_STREAMS-1:0]            pend_vec, grant_vec;
    logic [NUM_STREAMS-1:0][ID_W-1:0]  id_vec;
    logic [NUM_STREAMS-1:0][BLK_W-1:0] npf_vec;
    logic                              hit_any;
    logic [IDX_W-1:0]                  hit_idx, victim_idx, touch_idx;
    logic [AHEAD_W-1:0]                ahead_c;
    logic                              cand_v;
    logic [BLK_W-1:0]                  cand_blk;

    // Depth clamp: 0 reads as 1, values above the limit read as the limit
    always_comb begin
        if (dem_ahead == '0)
            ahead_c = AHEAD_W'(1);
        else if (int'(dem_ahead) > MAX_AHEAD)
            ahead_c = AHEAD_W'(MAX_AHEAD);
        else
            ahead_c = dem_ahead;
    end

    // Tag lookup across all entries
    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            match_vec[i] = vld_vec[i] && (id_vec[i] == dem_id);
            if (match_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // Per-entry update strobes for hit or allocation
    always_comb begin
        for (int i = 0; i < NUM_STREAMS; i++) begin
            hit_vec[i]   = dem_valid && match_vec[i];
            alloc_vec[i] = dem_valid && !hit_any && (victim_idx == IDX_W'(i));
        end
    end

    assign touch_idx = hit_any ? hit_idx : victim_idx;

    generate
        for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_ent
            pfs_entry #(
                .BLK_W  (BLK_W),
                .ID_W   (ID_W),
                .AHEAD_W(AHEAD_W)
            ) ent_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .alloc_i(alloc_vec[g]),
                .hit_i  (hit_vec[g]),
                .grant_i(grant_vec[g]),
                .id_i   (dem_id),
                .blk_i  (dem_blk),
                .ahead_i(ahead_c),
                .valid_o(vld_vec[g]),
                .id_o   (id_vec[g]),
                .pend_o (pend_vec[g]),
                .npf_o  (npf_vec[g])
            );
        end
    endgenerate

    pfs_lru #(
        .N    (NUM_STREAMS),
        .IDX_W(IDX_W)
    ) lru_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_i    (dem_valid),
        .touch_idx_i(touch_idx),
        .valid_i    (vld_vec),
        .victim_o   (victim_idx)
    );

    pfs_arb #(
        .N    (NUM_STREAMS),
        .BLK_W(BLK_W)
    ) arb_i (
        .pend_i    (pend_vec),
        .npf_i     (npf_vec),
        .grant_o   (grant_vec),
        .cand_v_o  (cand_v),
        .cand_blk_o(cand_blk)
    );

    pfs_outq #(
        .BLK_W(BLK_W)
    ) outq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_v_i  (cand_v),
        .cand_blk_i(cand_blk),
        .pf_ready  (pf_ready),
        .pf_valid  (pf_valid),
        .pf_blk    (pf_blk)
    );

endmodule

// File: rtl/pfs_chk.sv
// Module: protocol and arbitration checks for the stride prefetcher.
// Assumes: it is bound into stride_prefetcher and sees its internal
// candidate and grant signals.
module pfs_chk #(
    parameter int N     = 8,
    parameter int BLK_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pf_valid,
    input logic             pf_ready,
    input logic [BLK_W-1:0] pf_blk,
    input logic             cand_v,
    input logic [BLK_W-1:0] cand_blk,
    input logic [N-1:0]     grant_vec,
    input logic [N-1:0]     pend_vec
);

    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pf_valid);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_blk)));

    // R10
    load_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!pf_valid || pf_ready) && cand_v) |=> (pf_valid && (pf_blk == $past(cand_blk))));

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R3
    grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec & ~pend_vec) == '0);

    // R8
    cand_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_v |-> ($countones(grant_vec) == 1));

endmodule

bind stride_prefetcher pfs_chk #(
    .N    (NUM_STREAMS),
    .BLK_W(BLK_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pf_valid (pf_valid),
    .pf_ready (pf_ready),
    .pf_blk   (pf_blk),
    .cand_v   (cand_v),
    .cand_blk (cand_blk),
    .grant_vec(grant_vec),
    .pend_vec (pend_vec)
);

// File: tb/stride_prefetcher_tb_top.sv
// Bench: directed prefetch lists worked out by hand, plus seeded random
// traffic compared cycle by cycle with a behavioural model of the requirements.
module stride_prefetcher_tb_top;

    localparam int NS   = 8;
    localparam int MAXA = 12;
    localparam int BW   = 26;
    localparam int IW   = 6;
    localparam int AW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dem_valid = 1'b0;
    logic [IW-1:0] dem_id = '0;
    logic [BW-1:0] dem_blk = '0;
    logic [AW-1:0] dem_ahead = '0;
    logic          pf_valid;
    logic          pf_ready = 1'b1;
    logic [BW-1:0] pf_blk;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [BW-1:0] rec [64];
    int            rec_n = 0;

    // behavioural model state
    bit            m_vld [NS];
    int            m_id [NS];
    logic [BW-1:0] m_last [NS];
    logic [BW-1:0] m_str [NS];
    logic [BW-1:0] m_npf [NS];
    int            m_conf [NS];
    int            m_lead [NS];
    int            m_depth [NS];
    int            m_rank [NS];
    bit            m_sv;
    logic [BW-1:0] m_sb;

    always #5 clk = ~clk;

    stride_prefetcher dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dem_valid(dem_valid),
        .dem_id   (dem_id),
        .dem_blk  (dem_blk),
        .dem_ahead(dem_ahead),
        .pf_valid (pf_valid),
        .pf_ready (pf_ready),
        .pf_blk   (pf_blk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_vld[i] = 0; m_id[i] = 0; m_last[i] = '0; m_str[i] = '0;
            m_npf[i] = '0; m_conf[i] = 0; m_lead[i] = 0; m_depth[i] = 0;
            m_rank[i] = i;
        end
        m_sv = 0;
        m_sb = '0;
    endtask

    // One clock edge of the model, written from the requirements
    task automatic model_edge(input bit dv, input int id, input logic [BW-1:0] blk,
                              input int ah, input bit rdy);
        int g = -1;
        int t = -1;
        int hit = -1;
        int d;
        int r;
        logic [BW-1:0] dl;
        bit cv;
        logic [BW-1:0] cb;
        for (int i = 0; i < NS; i++)
            if (g < 0 && m_vld[i] && m_conf[i] == 2 && m_lead[i] < m_depth[i]) g = i;
        cv = (g >= 0);
        cb = cv ? m_npf[g] : '0;
        if (cv) begin
            m_npf[g] = m_npf[g] + m_str[g];
            m_lead[g]++;
        end
        d = (ah == 0) ? 1 : ((ah > MAXA) ? MAXA : ah);
        if (dv) begin
            for (int i = 0; i < NS; i++) if (m_vld[i] && m_id[i] == id) hit = i;
            if (hit >= 0) begin
                t = hit;
                dl = blk - m_last[hit];
                if (dl != '0) begin
                    m_depth[hit] = d;
                    m_last[hit] = blk;
                    if (dl != m_str[hit]) begin
                        m_str[hit] = dl; m_conf[hit] = 1; m_lead[hit] = 0;
                    end else if (m_conf[hit] == 1) begin
                        m_conf[hit] = 2; m_lead[hit] = 0; m_npf[hit] = blk + m_str[hit];
                    end else if (m_lead[hit] > 0) begin
                        m_lead[hit]--;
                    end else begin
                        m_npf[hit] = blk + m_str[hit];
                    end
                end
            end else begin
                for (int i = 0; i < NS; i++) if (t < 0 && !m_vld[i]) t = i;
                if (t < 0) for (int i = 0; i < NS; i++) if (m_rank[i] == NS - 1) t = i;
                m_vld[t] = 1; m_id[t] = id; m_last[t] = blk; m_str[t] = '0;
                m_conf[t] = 0; m_lead[t] = 0; m_npf[t] = '0; m_depth[t] = d;
            end
            r = m_rank[t];
            for (int i = 0; i < NS; i++) if (m_rank[i] < r) m_rank[i]++;
            m_rank[t] = 0;
        end
        if (!m_sv || rdy) begin
            m_sv = cv;
            m_sb = cb;
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, compare outputs
    task automatic step(input bit dv, input int id, input int blk, input int ah, input bit rdy);
        dem_valid = dv;
        dem_id    = IW'(id);
        dem_blk   = BW'(blk);
        dem_ahead = AW'(ah);
        pf_ready  = rdy;
        if (pf_valid && rdy && rec_n < 64) begin
            rec[rec_n] = pf_blk;
            rec_n++;
        end
        model_edge(dv, id, BW'(blk), ah, rdy);
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, 32'(pf_valid), 32'(m_sv));
        if (m_sv) chk(cur_req, 32'(pf_blk), 32'(m_sb));
    endtask

    task automatic idle(input int n, input bit rdy);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, rdy);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        dem_valid = 1'b0;
        pf_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        rec_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cur [12];
        int str [12];
        void'($urandom(32'd20240611));

        // R1: reset state
        do_reset();
        cur_req = "R1";
        chk("R1", 32'(pf_valid), 0);
        idle(4, 1);

        // R2 R3 R5: stride 4, depth 3
        do_reset();
        cur_req = "R2";
        step(1, 3, 100, 3, 1); idle(14, 1);
        step(1, 3, 104, 3, 1); idle(14, 1);
        chk("R2", 32'(rec_n), 0);
        step(1, 3, 108, 3, 1); idle(14, 1);
        chk("R2", 32'(rec_n), 3);
        chk("R2", 32'(rec[0]), 112);
        chk("R3", 32'(rec[1]), 116);
        chk("R3", 32'(rec[2]), 120);
        cur_req = "R5";
        step(1, 3, 112, 3, 1); idle(14, 1);
        chk("R5", 32'(rec_n), 4);
        chk("R5", 32'(rec[3]), 124);

        // R2: negative stride, depth 2
        do_reset();
        cur_req = "R2";
        step(1, 11, 1000, 2, 1); idle(3, 1);
        step(1, 11, 997, 2, 1); idle(3, 1);
        step(1, 11, 994, 2, 1); idle(6, 1);
        chk("R2", 32'(rec_n), 2);
        chk("R2", 32'(rec[0]), 991);
        chk("R2", 32'(rec[1]), 988);

        // R4: stride +1, depth 1
        do_reset();
        cur_req = "R4";
        for (int b = 200; b <= 204; b++) begin
            step(1, 5, b, 1, 1);
            idle(4, 1);
        end
        chk("R4", 32'(rec_n), 3);
        chk("R4", 32'(rec[0]), 203);
        chk("R4", 32'(rec[1]), 204);
        chk("R4", 32'(rec[2]), 205);

        // R6: stride change cancels and retrains
        do_reset();
        cur_req = "R6";
        step(1, 7, 300, 2, 1); idle(4, 1);
        step(1, 7, 302, 2, 1); idle(4, 1);
        step(1, 7, 304, 2, 1); idle(6, 1);
        step(1, 7, 310, 2, 1); idle(6, 1);
        chk("R6", 32'(rec_n), 2);
        step(1, 7, 316, 2, 1); idle(6, 1);
        chk("R6", 32'(rec_n), 4);
        chk("R6", 32'(rec[0]), 306);
        chk("R6", 32'(rec[1]), 308);
        chk("R6", 32'(rec[2]), 322);
        chk("R6", 32'(rec[3]), 328);

        // R7: repeated blocks are ignored
        do_reset();
        cur_req = "R7";
        step(1, 9, 400, 1, 1); step(1, 9, 400, 5, 1); idle(2, 1);
        step(1, 9, 404, 1, 1); step(1, 9, 404, 5, 1); idle(2, 1);
        step(1, 9, 408, 1, 1); idle(6, 1);
        chk("R7", 32'(rec_n), 1);
        chk("R7", 32'(rec[0]), 412);
        for (int i = 0; i < 4; i++) step(1, 10, 500, 3, 1);
        idle(6, 1);
        chk("R7", 32'(rec_n), 1);

        // R3: depth clamp at both ends
        do_reset();
        cur_req = "R3";
        step(1, 50, 0, 15, 1); step(1, 50, 1, 15, 1); step(1, 50, 2, 15, 1);
        idle(16, 1);
        chk("R3", 32'(rec_n), 12);
        chk("R3", 32'(rec[0]), 3);
        chk("R3", 32'(rec[11]), 14);
        rec_n = 0;
        step(1, 51, 'h800, 0, 1); step(1, 51, 'h802, 0, 1); step(1, 51, 'h804, 0, 1);
        idle(6, 1);
        chk("R3", 32'(rec_n), 1);
        chk("R3", 32'(rec[0]), 'h806);

        // R9: least recently used replacement
        do_reset();
        cur_req = "R9";
        step(1, 20, 'h40, 1, 1); step(1, 20, 'h48, 1, 1); step(1, 20, 'h50, 1, 1);
        idle(4, 1);
        for (int i = 21; i <= 27; i++) step(1, i, 'h1000 + i, 1, 1);
        step(1, 20, 'h58, 1, 1); idle(4, 1);
        step(1, 28, 'h2000, 1, 1);
        step(1, 20, 'h60, 1, 1); idle(4, 1);
        for (int i = 22; i <= 27; i++) step(1, i, 'h1000 + i, 1, 1);
        step(1, 28, 'h2000, 1, 1);
        step(1, 30, 'h3000, 1, 1);
        step(1, 20, 'h68, 1, 1); idle(4, 1);
        step(1, 20, 'h70, 1, 1); idle(4, 1);
        chk("R9", 32'(rec_n), 3);
        chk("R9", 32'(rec[0]), 'h58);
        chk("R9", 32'(rec[1]), 'h60);
        chk("R9", 32'(rec[2]), 'h68);

        // R10: back-pressure holds one request and discards the rest
        do_reset();
        cur_req = "R10";
        step(1, 40, 'h100, 4, 0); idle(3, 0);
        step(1, 40, 'h101, 4, 0); idle(3, 0);
        step(1, 40, 'h102, 4, 0); idle(8, 0);
        chk("R10", 32'(pf_valid), 1);
        chk("R10", 32'(pf_blk), 'h103);
        idle(10, 1);
        chk("R10", 32'(rec_n), 1);
        chk("R10", 32'(rec[0]), 'h103);

        // R8: random traffic over more tags than entries
        do_reset();
        cur_req = "R8";
        for (int i = 0; i < 12; i++) begin
            cur[i] = i * 4096;
            str[i] = (i % 3) + 1;
        end
        for (int c = 0; c < 3000; c++) begin
            int id;
            bit dv;
            id = $urandom % 12;
            dv = ($urandom % 4) != 0;
            if (($urandom % 20) == 0) begin
                case ($urandom % 7)
                    0: str[id] = 1;
                    1: str[id] = 2;
                    2: str[id] = 3;
                    3: str[id] = -1;
                    4: str[id] = -4;
                    5: str[id] = 0;
                    default: str[id] = 7;
                endcase
            end
            if (dv) cur[id] = cur[id] + str[id];
            step(dv, id, cur[id], $urandom % 16, ($urandom % 10) < 7);
        end
        idle(20, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule